// File: doc/BRIEF.md
# Almost-Flag Offset Programming Controller

This block sits beside a 512-word FIFO. It owns the two threshold offsets that the FIFO's flag logic uses: the almost-empty offset (`ae_offset`) and the almost-full offset (`af_offset`). The two mode pins `sel_en_n` and `sel_data` choose how the offsets get their values. The block records the mode while reset is held and keeps it until the next reset. There are four modes:

- Two fixed presets.
- A parallel load that takes the first two accepted FIFO writes.
- A serial load. In this mode the same two pins become a serial-enable (active low) and a serial data input, clocked by the write clock.

The block tells the FIFO when writes may be accepted through `wr_allow`. The FIFO combines this with its own full state to form input-ready. The block also tells the FIFO, through `wr_divert`, that the current write belongs to an offset register and must not reach memory. Reset is synchronous to the write clock. The mode in force is the pin pair sampled at the last clock edge on which `rst_n` is low. `wr_qual` is the FIFO's fully qualified write attempt: chip select, direction, enable and mailbox deselect are already combined. A write takes effect only while `wr_allow` is high.

Top module: `ofs_prog_ctrl`

## Requirements
- R1: The mode is the value {`sel_en_n`,`sel_data`} at the last rising clock edge with `rst_n` low, decoded as 11 = serial, 10 = preset 64, 01 = preset 8, 00 = parallel. After release, pin changes never alter the mode.
- R2: In either preset mode, both offsets equal the preset value from the first reset edge onward, and `wr_divert` stays low.
- R3: `wr_allow` is low while in reset. In preset and parallel modes, it is low after the first rising edge following release and high after the second.
- R4: In parallel mode, `wr_divert` is high from the moment `wr_allow` rises until two writes are accepted. The first accepted write loads `af_offset` and the second loads `ae_offset`, each from `wr_low[8:0]`, where bit 8 is the MSB.
- R5: Once both parallel loads are done, `wr_divert` is low and further writes leave both offsets unchanged.
- R6: A `wr_qual` pulse while `wr_allow` is low loads nothing.
- R7: In serial mode, each rising edge with `sel_en_n` low shifts in one `sel_data` bit. An edge with `sel_en_n` high changes nothing.
- R8: The serial stream is 18 bits. The first bit is bit 8 of `af_offset` and the last bit is bit 0 of `ae_offset`. Between loads, {`af_offset`,`ae_offset`} shows the bits received so far, right-aligned.
- R9: In serial mode, `wr_allow` stays low through the edge that takes the 18th bit and rises on the next edge.
- R10: After 18 serial bits, further `sel_en_n`/`sel_data` activity leaves both offsets unchanged.
- R11: Asserting reset at any point abandons a load in progress, clears non-preset offsets to zero and recaptures the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous reset, active low; mode sampled while low |
| sel_en_n | input | 1 | Mode select high bit; serial enable (active low) after release |
| sel_data | input | 1 | Mode select low bit; serial data after release |
| wr_qual | input | 1 | Qualified FIFO write attempt |
| wr_low | input | 9 | Low bits of the write data bus |
| ae_offset | output | 9 | Almost-empty offset |
| af_offset | output | 9 | Almost-full offset |
| wr_allow | output | 1 | Writes may be accepted (gates input-ready) |
| wr_divert | output | 1 | Current write targets an offset register, not memory |

## Verification
The embedded properties assume that the mode pins are steady across the last reset edge. They also assume that `wr_qual`, `wr_low` and the serial pins change only away from the rising edge. The bench respects this by changing every input 1 ns after an edge and holding reset for four edges. The offset ranges (1 to 508) are taken as the writer's duty, so the bench only loads values inside that range, including both end points. The serial runs insert enable-high gap cycles carrying the wrong data bit.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

    // Encoding matters: it is {sel_en_n, sel_data} sampled in reset.
    typedef enum logic [1:0] {
        MODE_PARLOAD  = 2'b00,
        MODE_PRESET_S = 2'b01,
        MODE_PRESET_L = 2'b10,
        MODE_SERIAL   = 2'b11
    } ofs_mode_e;

    typedef enum logic [2:0] {
        ST_CAPT,
        ST_HOLD,
        ST_LOAD_HI,
        ST_LOAD_LO,
        ST_SHIFT,
        ST_RUN
    } ofs_state_e;

endpackage

// File: rtl/ofs_mode_decode.sv
module ofs_mode_decode
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W        = 9,
    parameter int PRESET_SMALL = 8,
    parameter int PRESET_LARGE = 64
) (
    input  logic [1:0]       sel,
    output ofs_mode_e        mode,
    output logic             is_preset,
    output logic [OFS_W-1:0] preset_val
);

    always_comb begin
        mode       = ofs_mode_e'(sel);
        is_preset  = 1'b0;
        preset_val = '0;
        case (mode)
            MODE_PRESET_S: begin
                is_preset  = 1'b1;
                preset_val = OFS_W'(PRESET_SMALL);
            end
            MODE_PRESET_L: begin
                is_preset  = 1'b1;
                preset_val = OFS_W'(PRESET_LARGE);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ofs_bit_shifter.sv
module ofs_bit_shifter #(
    parameter int BITS = 18
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] word,
    output logic            full
);

    localparam int CNT_W = $clog2(BITS + 1);

    typedef struct packed {
        logic [BITS-1:0]  word;
        logic [CNT_W-1:0] count;
    } shf_t;

    shf_t cur_q, nx_d;

    assign full = (cur_q.count == CNT_W'(BITS));
    assign word = cur_q.word;

    always_comb begin
        nx_d = cur_q;
        if (clr) begin
            nx_d.word  = '0;
            nx_d.count = '0;
        end else if (shift_en && !full) begin
            nx_d.word  = {cur_q.word[BITS-2:0], bit_in};
            nx_d.count = cur_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nx_d;
    end

    // R10: once complete, the word is frozen until the next clear
    a_r10_full_frozen: assert property (@(posedge clk) disable iff (clr)
        full |=> (full && $stable(word)));

    // R7: no enable, no movement
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (clr)
        !shift_en |=> $stable(word));

endmodule

// File: rtl/ofs_prog_ctrl.sv
module ofs_prog_ctrl
    import ofs_prog_pkg::*;
#(
    parameter int DEPTH         = 512,
    parameter int OFS_W         = $clog2(DEPTH),
    parameter int PRESET_SMALL  = 8,
    parameter int PRESET_LARGE  = 64,
    parameter int RELEASE_EDGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_en_n,
    input  logic             sel_data,
    input  logic             wr_qual,
    input  logic [OFS_W-1:0] wr_low,
    output logic [OFS_W-1:0] ae_offset,
    output logic [OFS_W-1:0] af_offset,
    output logic             wr_allow,
    output logic             wr_divert
);

    localparam int SER_BITS = 2 * OFS_W;
    localparam int HOLD_W   = $clog2(RELEASE_EDGES + 1);

    typedef struct packed {
        ofs_state_e        state;
        ofs_mode_e         mode;
        logic [HOLD_W-1:0] hold;
        logic [OFS_W-1:0]  ae;
        logic [OFS_W-1:0]  af;
    } ctl_t;

    ctl_t cur_q, nx_d;

    ofs_mode_e             dec_mode;
    logic                  dec_is_preset;
    logic [OFS_W-1:0]      dec_preset;
    logic [SER_BITS-1:0]   chain_word;
    logic                  chain_full;
    logic                  chain_shift;

    ofs_mode_decode #(
        .OFS_W       (OFS_W),
        .PRESET_SMALL(PRESET_SMALL),
        .PRESET_LARGE(PRESET_LARGE)
    ) u_decode (
        .sel       ({sel_en_n, sel_data}),
        .mode      (dec_mode),
        .is_preset (dec_is_preset),
        .preset_val(dec_preset)
    );

    assign chain_shift = rst_n && (cur_q.mode == MODE_SERIAL) && !sel_en_n;

    ofs_bit_shifter #(
        .BITS(SER_BITS)
    ) u_shifter (
        .clk     (clk),
        .clr     (!rst_n),
        .shift_en(chain_shift),
        .bit_in  (sel_data),
        .word    (chain_word),
        .full    (chain_full)
    );

    always_comb begin
        nx_d = cur_q;
        if (!rst_n) begin
            nx_d.state = ST_CAPT;
            nx_d.mode  = dec_mode;
            nx_d.hold  = '0;
            nx_d.ae    = dec_is_preset ? dec_preset : '0;
            nx_d.af    = dec_is_preset ? dec_preset : '0;
        end else begin
            case (cur_q.state)
                ST_CAPT: begin
                    nx_d.state = (cur_q.mode == MODE_SERIAL) ? ST_SHIFT : ST_HOLD;
                    nx_d.hold  = HOLD_W'(1);
                end
                ST_HOLD: begin
                    if (cur_q.hold >= HOLD_W'(RELEASE_EDGES - 1)) begin
                        nx_d.state = (cur_q.mode == MODE_PARLOAD) ? ST_LOAD_HI : ST_RUN;
                    end else begin
                        nx_d.hold = cur_q.hold + HOLD_W'(1);
                    end
                end
                ST_LOAD_HI: begin
                    if (wr_qual) begin
                        nx_d.af    = wr_low;
                        nx_d.state = ST_LOAD_LO;
                    end
                end
                ST_LOAD_LO: begin
                    if (wr_qual) begin
                        nx_d.ae    = wr_low;
                        nx_d.state = ST_RUN;
                    end
                end
                ST_SHIFT: begin
                    if (chain_full) nx_d.state = ST_RUN;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nx_d;
    end

    assign ae_offset = (cur_q.mode == MODE_SERIAL) ? chain_word[OFS_W-1:0] : cur_q.ae;
    assign af_offset = (cur_q.mode == MODE_SERIAL) ? chain_word[SER_BITS-1:OFS_W] : cur_q.af;
    assign wr_allow  = (cur_q.state == ST_LOAD_HI) || (cur_q.state == ST_LOAD_LO)
                    || (cur_q.state == ST_RUN);
    assign wr_divert = (cur_q.state == ST_LOAD_HI) || (cur_q.state == ST_LOAD_LO);

    // R1: the captured mode never moves outside reset
    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cur_q.mode));

    // R4: a diverted write is always an accepted write
    a_r4_divert_needs_allow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_divert |-> wr_allow);

    // R3: outside serial mode, writes open only after the release timer
    a_r3_allow_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_allow) && cur_q.mode != MODE_SERIAL) |-> $past(cur_q.state == ST_HOLD));

    // R9: serial mode opens writes only with a complete stream
    a_r9_serial_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode == MODE_SERIAL && wr_allow) |-> chain_full);

    // R5: offsets are frozen in normal running
    a_r5_offsets_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_RUN) |=> ($stable(ae_offset) && $stable(af_offset)));

endmodule

// File: tb/ofs_prog_ctrl_tb.sv
module ofs_prog_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_en_n = 1'b0;
    logic       sel_data = 1'b0;
    logic       wr_qual = 1'b0;
    logic [8:0] wr_low = '0;
    logic [8:0] ae_offset, af_offset;
    logic       wr_allow, wr_divert;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ofs_prog_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_en_n (sel_en_n),
        .sel_data (sel_data),
        .wr_qual  (wr_qual),
        .wr_low   (wr_low),
        .ae_offset(ae_offset),
        .af_offset(af_offset),
        .wr_allow (wr_allow),
        .wr_divert(wr_divert)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hold_reset(input logic a, input logic b, input int exp_ofs);
        rst_n = 1'b0; sel_en_n = a; sel_data = b; wr_qual = 1'b0;
        repeat (4) tick();
        chk(wr_allow == 1'b0, "R3 reset allow", int'(wr_allow), 0);
        chk(wr_divert == 1'b0, "R11 reset divert", int'(wr_divert), 0);
        chk(ae_offset == exp_ofs && af_offset == exp_ofs, "R11 reset offsets",
            int'(ae_offset), exp_ofs);
        rst_n = 1'b1;
    endtask

    task automatic preset_run(input logic a, input logic b, input int val);
        hold_reset(a, b, val);
        sel_en_n = ~a; sel_data = ~b;   // R1: pin changes after release
        tick();
        chk(wr_allow == 1'b0, "R3 edge1", int'(wr_allow), 0);
        tick();
        chk(wr_allow == 1'b1, "R3 edge2", int'(wr_allow), 1);
        chk(wr_divert == 1'b0, "R2 divert", int'(wr_divert), 0);
        wr_qual = 1'b1; wr_low = 9'd300;
        repeat (3) tick();
        wr_qual = 1'b0;
        chk(ae_offset == val, "R1 ae kept", int'(ae_offset), val);
        chk(af_offset == val, "R2 af preset", int'(af_offset), val);
    endtask

    task automatic parallel_run(input int y, input int x);
        hold_reset(1'b0, 1'b0, 0);
        wr_qual = 1'b1; wr_low = 9'h1AA;          // R6: before allow
        tick();
        chk(wr_allow == 1'b0, "R3 par edge1", int'(wr_allow), 0);
        tick();
        chk(wr_allow == 1'b1 && wr_divert == 1'b1, "R4 par open", int'(wr_divert), 1);
        chk(af_offset == 0 && ae_offset == 0, "R6 early write ignored", int'(af_offset), 0);
        wr_low = 9'(y);
        tick();
        chk(af_offset == y, "R4 af load", int'(af_offset), y);
        chk(ae_offset == 0 && wr_divert == 1'b1, "R4 ae pending", int'(ae_offset), 0);
        wr_qual = 1'b0; wr_low = 9'(x);
        tick();
        chk(ae_offset == 0, "R4 idle cycle", int'(ae_offset), 0);
        wr_qual = 1'b1;
        tick();
        chk(ae_offset == x, "R4 ae load", int'(ae_offset), x);
        chk(wr_divert == 1'b0, "R5 divert off", int'(wr_divert), 0);
        wr_low = ~9'(x);
        repeat (2) tick();
        wr_qual = 1'b0;
        chk(af_offset == y && ae_offset == x, "R5 later writes", int'(af_offset), y);
    endtask

    task automatic serial_run(input int y, input int x);
        logic [17:0] w;
        w = {9'(y), 9'(x)};
        hold_reset(1'b1, 1'b1, 0);
        tick();
        chk(wr_allow == 1'b0, "R9 ser edge1", int'(wr_allow), 0);
        for (int i = 0; i < 18; i++) begin
            if (i % 3 == 1) begin
                sel_en_n = 1'b1; sel_data = ~w[17-i];
                tick();
                chk({af_offset, ae_offset} == (w >> (18 - i)), "R7 gap hold",
                    int'({af_offset, ae_offset}), int'(w >> (18 - i)));
            end
            sel_en_n = 1'b0; sel_data = w[17-i];
            tick();
            chk({af_offset, ae_offset} == (w >> (17 - i)), "R8 stream",
                int'({af_offset, ae_offset}), int'(w >> (17 - i)));
            chk(wr_allow == 1'b0, "R9 held low", int'(wr_allow), 0);
        end
        sel_en_n = 1'b1;
        tick();
        chk(wr_allow == 1'b1, "R9 release", int'(wr_allow), 1);
        for (int j = 0; j < 4; j++) begin
            sel_en_n = 1'b0; sel_data = j[0];
            tick();
        end
        sel_en_n = 1'b1;
        chk(af_offset == y && ae_offset == x, "R10 extra bits", int'(ae_offset), x);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        preset_run(1'b0, 1'b1, 8);
        preset_run(1'b1, 1'b0, 64);
        parallel_run(508, 1);
        parallel_run(1, 508);
        for (int k = 0; k < 12; k++)
            parallel_run((k * 37) % 508 + 1, (k * 101 + 9) % 508 + 1);
        serial_run(508, 1);
        serial_run(1, 508);
        for (int k = 0; k < 8; k++)
            serial_run((k * 61) % 508 + 1, (k * 173 + 5) % 508 + 1);

        // R11: abort a parallel load after Y, restart in preset 8
        hold_reset(1'b0, 1'b0, 0);
        repeat (2) tick();
        wr_qual = 1'b1; wr_low = 9'd77;
        tick();
        wr_qual = 1'b0;
        hold_reset(1'b0, 1'b1, 8);
        repeat (2) tick();
        chk(af_offset == 8 && ae_offset == 8 && wr_divert == 1'b0, "R11 abort parallel",
            int'(af_offset), 8);

        // R11: abort a serial load midway, restart in parallel
        hold_reset(1'b1, 1'b1, 0);
        for (int i = 0; i < 5; i++) begin
            sel_en_n = 1'b0; sel_data = 1'b1;
            tick();
        end
        hold_reset(1'b0, 1'b0, 0);
        repeat (2) tick();
        chk(wr_divert == 1'b1, "R11 recapture parallel", int'(wr_divert), 1);
        parallel_run(200, 3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule